// File: doc/BRIEF.md
# Interlocked Two-Wire Byte Port

This block moves bytes between a processor and an external parallel bus. It uses a fully interlocked, four-edge handshake on two wires: an active-low "data valid" strobe and an active-high "ready" line. The processor selects the direction with one level input.

When the port receives, the strobe is an input and ready is an output. An external sender puts a byte on the data lines and pulls the strobe low. The port captures the byte and drops ready. It raises ready again once the strobe has returned high. The byte is then held for the processor behind an "available" flag.

When the port sends, the roles of the two wires swap. A processor write puts the byte on the data lines and the port pulls its own strobe low one clock later. It releases the strobe after the external receiver has dropped ready. The transfer completes when ready comes back high.

The external strobe and ready inputs pass through a two-flop synchronizer, and the incoming data lines pass through the same pipeline. The captured byte is therefore the value that was present when the strobe fell, even if the sender changes the data right after that edge.

Top module: `hsk_port`

## Requirements
- R1: While `rst_n` is low and directly after reset: `rdy_out`=1, `dav_out_n`=1, `rx_avail`=0, `tx_done`=0, `tx_overrun`=0.
- R2: Receive mode (`dir_out`=0), with `rdy_out` high. On the third rising clock edge after `dav_in_n` falls, and not before, three things happen: `rdy_out` drops to 0, `cpu_rdata` takes the byte that was on `pin_data_in` at the first edge that saw the strobe low, and `rx_avail` goes to 1. Data changes after that first edge do not affect the captured byte.
- R3: Receive mode, with `rdy_out` low. `rdy_out` returns to 1 on the third rising edge after `dav_in_n` rises, and not before.
- R4: Receive mode, while `rdy_out` is low. Changes on `pin_data_in` do not alter `cpu_rdata`. No new byte is taken until the strobe has risen and fallen again.
- R5: A `cpu_rd` pulse clears `rx_avail` at the next edge. If a new byte is captured on that same edge, `rx_avail` stays 1.
- R6: Send mode (`dir_out`=1), with the port idle. A `cpu_wr` pulse puts `cpu_wdata` on `pin_data_out` at the next edge, with `pin_data_oe`=1. `dav_out_n` falls one edge later, so the data leads the strobe by one clock period. An accepted write clears `tx_done`.
- R7: Send mode. `dav_out_n` rises on the third rising edge after `rdy_in` falls, and not before.
- R8: Send mode. `tx_done` goes to 1 on the third rising edge after `rdy_in` rises following the strobe release. After an accepted write, `dav_out_n` falls only once synchronized `rdy_in` is high: it falls on the third edge after `rdy_in` rises if `rdy_in` was low.
- R9: Send mode. A `cpu_wr` while a transfer is in progress is ignored, leaving `pin_data_out` unchanged, and sets `tx_overrun`. `tx_overrun` stays set until a `cpu_rd` pulse clears it.
- R10: Receive mode keeps `dav_out_n`=1 and `pin_data_oe`=0, and `cpu_wr` has no effect on the output side. Send mode keeps `rdy_out`=1, and `dav_in_n` has no effect on `rx_avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 = send mode, 0 = receive mode |
| cpu_wr | input | 1 | Processor write pulse, starts a send |
| cpu_wdata | input | DATA_W | Byte to send |
| cpu_rd | input | 1 | Processor read pulse, clears `rx_avail` and `tx_overrun` |
| cpu_rdata | output | DATA_W | Last received byte |
| rx_avail | output | 1 | A received byte waits to be read |
| tx_done | output | 1 | Last send completed |
| tx_overrun | output | 1 | Sticky: a write arrived while busy |
| pin_data_in | input | DATA_W | Parallel data lines, inbound |
| pin_data_out | output | DATA_W | Parallel data lines, outbound |
| pin_data_oe | output | 1 | Output enable for the data lines |
| dav_in_n | input | 1 | External active-low data-valid strobe |
| dav_out_n | output | 1 | Own active-low data-valid strobe |
| rdy_in | input | 1 | External ready |
| rdy_out | output | 1 | Own ready |

## Verification
Every reaction to an external wire takes exactly three rising edges: two synchronizer stages and one state register. Every reaction to a processor pulse takes one edge, and the send strobe follows one edge after that. The bench drives all inputs 2 ns after a rising edge and then waits a counted number of edges. It checks each output both one edge before its due cycle, where the old value must still be there, and on the due cycle itself. This makes an early response fail as surely as a late one.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic {
        RX_WAIT_FALL,
        RX_WAIT_RISE
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SETUP,
        TX_WAIT_ACK,
        TX_WAIT_REL
    } tx_state_e;

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/hsk_rx.sv
module hsk_rx
    import hsk_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          dav_n,
    input  logic [DW-1:0] pin_data,
    input  logic          rd_ack,
    output logic          rdy,
    output logic [DW-1:0] byte_q,
    output logic          avail
);
    localparam int SW = DW + 1;

    typedef struct packed {
        rx_state_e     st;
        logic [DW-1:0] data;
        logic          avail;
        logic          dav_prev;
    } rx_reg_t;

    logic [SW-1:0] sync_q;
    logic          dav_s;
    logic [DW-1:0] data_s;
    logic          fall, rise;
    rx_reg_t       r_d, r_q;

    hsk_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, {DW{1'b0}}})
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dav_n, pin_data}),
        .q     (sync_q)
    );

    assign dav_s  = sync_q[DW];
    assign data_s = sync_q[DW-1:0];
    assign fall   = r_q.dav_prev & ~dav_s;
    assign rise   = ~r_q.dav_prev & dav_s;

    always_comb begin
        r_d          = r_q;
        r_d.dav_prev = dav_s;
        if (rd_ack) begin
            r_d.avail = 1'b0;
        end
        if (!enable) begin
            r_d.st = RX_WAIT_FALL;
        end else begin
            unique case (r_q.st)
                RX_WAIT_FALL: begin
                    if (fall) begin
                        r_d.data  = data_s;
                        r_d.avail = 1'b1;
                        r_d.st    = RX_WAIT_RISE;
                    end
                end
                RX_WAIT_RISE: begin
                    if (rise) begin
                        r_d.st = RX_WAIT_FALL;
                    end
                end
                default: r_d.st = RX_WAIT_FALL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RX_WAIT_FALL, data: '0, avail: 1'b0, dav_prev: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign rdy    = (r_q.st == RX_WAIT_FALL);
    assign byte_q = r_q.data;
    assign avail  = r_q.avail;

    p_capture_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> avail)
        else $error("ready dropped without a byte becoming available");

    p_release_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $rose(rdy) |-> $past(dav_s))
        else $error("ready rose while synchronized strobe was low");

    p_hold_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && $past(!rdy)) |-> $stable(byte_q))
        else $error("captured byte changed during held handshake");
endmodule

// File: rtl/hsk_tx.sv
module hsk_tx
    import hsk_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rdy_in,
    input  logic          ovr_clr,
    output logic          dav_n,
    output logic [DW-1:0] data_out,
    output logic          done,
    output logic          ovr
);
    typedef struct packed {
        tx_state_e     st;
        logic [DW-1:0] data;
        logic          done;
        logic          ovr;
    } tx_reg_t;

    logic    rdy_s;
    tx_reg_t r_d, r_q;

    hsk_sync #(
        .W       (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rdy_in),
        .q     (rdy_s)
    );

    always_comb begin
        r_d = r_q;
        if (ovr_clr) begin
            r_d.ovr = 1'b0;
        end
        if (!enable) begin
            r_d.st = TX_IDLE;
        end else begin
            unique case (r_q.st)
                TX_IDLE: begin
                    if (wr) begin
                        r_d.data = wdata;
                        r_d.done = 1'b0;
                        r_d.st   = TX_SETUP;
                    end
                end
                TX_SETUP: begin
                    if (rdy_s) begin
                        r_d.st = TX_WAIT_ACK;
                    end
                end
                TX_WAIT_ACK: begin
                    if (!rdy_s) begin
                        r_d.st = TX_WAIT_REL;
                    end
                end
                TX_WAIT_REL: begin
                    if (rdy_s) begin
                        r_d.st   = TX_IDLE;
                        r_d.done = 1'b1;
                    end
                end
                default: r_d.st = TX_IDLE;
            endcase
            if (wr && (r_q.st != TX_IDLE)) begin
                r_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: TX_IDLE, data: '0, done: 1'b0, ovr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dav_n    = (r_q.st != TX_WAIT_ACK);
    assign data_out = r_q.data;
    assign done     = r_q.done;
    assign ovr      = r_q.ovr;

    p_data_leads_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_n) |-> $stable(data_out))
        else $error("strobe fell in the same cycle the data changed");

    p_release_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $rose(dav_n) |-> $past(!rdy_s))
        else $error("strobe released before ready fell");

    p_issue_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_n) |-> $past(rdy_s))
        else $error("strobe issued while ready was low");
endmodule

// File: rtl/hsk_port.sv
module hsk_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rx_avail,
    output logic              tx_done,
    output logic              tx_overrun,
    input  logic [DATA_W-1:0] pin_data_in,
    output logic [DATA_W-1:0] pin_data_out,
    output logic              pin_data_oe,
    input  logic              dav_in_n,
    output logic              dav_out_n,
    input  logic              rdy_in,
    output logic              rdy_out
);
    hsk_rx #(
        .DW          (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!dir_out),
        .dav_n    (dav_in_n),
        .pin_data (pin_data_in),
        .rd_ack   (cpu_rd),
        .rdy      (rdy_out),
        .byte_q   (cpu_rdata),
        .avail    (rx_avail)
    );

    hsk_tx #(
        .DW          (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (dir_out),
        .wr       (cpu_wr),
        .wdata    (cpu_wdata),
        .rdy_in   (rdy_in),
        .ovr_clr  (cpu_rd),
        .dav_n    (dav_out_n),
        .data_out (pin_data_out),
        .done     (tx_done),
        .ovr      (tx_overrun)
    );

    assign pin_data_oe = dir_out;

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overrun && !cpu_rd) |=> tx_overrun)
        else $error("overrun flag cleared without a read");

    p_rx_mode_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |-> dav_out_n)
        else $error("send strobe active in receive mode");

    p_tx_mode_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && $past(dir_out)) |-> rdy_out)
        else $error("ready output low in send mode");

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (dav_out_n && rdy_out && !rx_avail && !tx_done && !tx_overrun))
        else $error("outputs not idle during reset");
endmodule

// File: tb/test_hsk_port.sv
module test_hsk_port;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir_out = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_rd = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic          rx_avail, tx_done, tx_overrun;
    logic [DW-1:0] pin_data_in = '0;
    logic [DW-1:0] pin_data_out;
    logic          pin_data_oe;
    logic          dav_in_n = 1'b1;
    logic          dav_out_n;
    logic          rdy_in = 1'b1;
    logic          rdy_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hsk_port #(.DATA_W(DW)) i_hsk_port (
        .clk (clk), .rst_n (rst_n), .dir_out (dir_out),
        .cpu_wr (cpu_wr), .cpu_wdata (cpu_wdata), .cpu_rd (cpu_rd),
        .cpu_rdata (cpu_rdata), .rx_avail (rx_avail), .tx_done (tx_done),
        .tx_overrun (tx_overrun), .pin_data_in (pin_data_in),
        .pin_data_out (pin_data_out), .pin_data_oe (pin_data_oe),
        .dav_in_n (dav_in_n), .dav_out_n (dav_out_n),
        .rdy_in (rdy_in), .rdy_out (rdy_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_rd();
        cpu_rd = 1'b1; step(1); cpu_rd = 1'b0;
    endtask

    task automatic pulse_wr(input logic [DW-1:0] b);
        cpu_wdata = b; cpu_wr = 1'b1; step(1); cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        #3;
        chk("R1 rdy_out in reset", rdy_out, 1);
        chk("R1 dav_out_n in reset", dav_out_n, 1);
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R1 rx_avail", rx_avail, 0);
        chk("R1 tx_done", tx_done, 0);
        chk("R1 tx_overrun", tx_overrun, 0);
        chk("R1 rdy_out", rdy_out, 1);
    endtask

    task automatic t_rx_capture(input logic [DW-1:0] b);
        pin_data_in = b; step(1);
        dav_in_n = 1'b0; step(1);
        pin_data_in = ~b;               // change right after the sampling edge
        step(1);
        chk("R2 rdy_out not early", rdy_out, 1);
        step(1);
        chk("R2 rdy_out low", rdy_out, 0);
        chk("R2 captured byte", cpu_rdata, b);
        chk("R2 rx_avail set", rx_avail, 1);
        pin_data_in = 8'h00; step(3);
        chk("R4 byte held while busy", cpu_rdata, b);
        dav_in_n = 1'b1; step(2);
        chk("R3 rdy_out not early", rdy_out, 0);
        step(1);
        chk("R3 rdy_out high", rdy_out, 1);
        chk("R4 byte after release", cpu_rdata, b);
    endtask

    task automatic t_rx_read();
        pulse_rd();
        chk("R5 read clears rx_avail", rx_avail, 0);
        pin_data_in = 8'h77; step(1);
        dav_in_n = 1'b0; step(2);
        cpu_rd = 1'b1; step(1); cpu_rd = 1'b0;
        chk("R5 capture beats read", rx_avail, 1);
        chk("R5 new byte", cpu_rdata, 8'h77);
        dav_in_n = 1'b1; step(3);
        pulse_rd();
        chk("R5 cleared again", rx_avail, 0);
    endtask

    task automatic t_tx_basic();
        dir_out = 1'b1; step(1);
        pulse_wr(8'hA5);
        chk("R6 data on lines", pin_data_out, 8'hA5);
        chk("R6 output enable", pin_data_oe, 1);
        chk("R6 strobe not yet", dav_out_n, 1);
        step(1);
        chk("R6 strobe low", dav_out_n, 0);
        pulse_wr(8'h3C);
        chk("R9 overrun set", tx_overrun, 1);
        chk("R9 busy write ignored", pin_data_out, 8'hA5);
        rdy_in = 1'b0; step(2);
        chk("R7 strobe held", dav_out_n, 0);
        step(1);
        chk("R7 strobe released", dav_out_n, 1);
        rdy_in = 1'b1; step(2);
        chk("R8 done not early", tx_done, 0);
        step(1);
        chk("R8 done set", tx_done, 1);
        pulse_wr(8'h5A);
        chk("R6 write clears done", tx_done, 0);
        chk("R9 overrun sticky", tx_overrun, 1);
        pulse_rd();
        chk("R9 read clears overrun", tx_overrun, 0);
        rdy_in = 1'b0; step(3);
        rdy_in = 1'b1; step(3);
        chk("R8 second done", tx_done, 1);
    endtask

    task automatic t_tx_wait_ready();
        rdy_in = 1'b0; step(3);
        pulse_wr(8'hC3);
        step(3);
        chk("R8 no strobe while ready low", dav_out_n, 1);
        rdy_in = 1'b1; step(2);
        chk("R8 strobe waits for sync", dav_out_n, 1);
        step(1);
        chk("R8 strobe after ready high", dav_out_n, 0);
        rdy_in = 1'b0; step(3);
        rdy_in = 1'b1; step(3);
        chk("R8 done after wait", tx_done, 1);
    endtask

    task automatic t_mode_isolation();
        dav_in_n = 1'b0; step(4);
        chk("R10 rx_avail unaffected in send mode", rx_avail, 0);
        chk("R10 rdy_out high in send mode", rdy_out, 1);
        dav_in_n = 1'b1; step(3);
        dir_out = 1'b0; step(1);
        pulse_wr(8'h99);
        step(2);
        chk("R10 no strobe in receive mode", dav_out_n, 1);
        chk("R10 lines not driven", pin_data_oe, 0);
        chk("R10 write ignored", pin_data_out, 8'h5A ^ 8'h5A ^ 8'hC3);
        chk("R10 no overrun", tx_overrun, 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_rx_capture(8'h5C);
        t_rx_capture(8'hE1);
        t_rx_read();
        t_tx_basic();
        t_tx_wait_ready();
        t_mode_isolation();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule